// File: doc/BRIEF.md
# Camera Byte-Stream Pixel Formatter

This block receives the raw parallel output of a camera sensor: an 8-bit data bus with a pixel clock and separate horizontal and vertical sync lines. The block runs on its own system clock. It oversamples the pixel clock through a short synchronizer and takes one byte on each selected pixel-clock edge while the horizontal sync is at its active level. The bytes are grouped into pixels: four bytes make a pair of pixels for YCbCr 4:2:2 input, and two bytes make one pixel for RGB565 input. Each input format has four byte orders to choose from.

Each pixel leaves the block as one 16-bit word with a valid strobe and two markers, one for the first pixel of a frame and one for the first pixel of a line. The output word can be YCbCr 4:2:2 (luma plus alternating chroma), luma only, RGB555 or RGB565. Luma and chroma can be posterized, which means each component is ANDed with its own mask. A monochrome switch replaces the chroma with a neutral value. All format settings are copied into shadow registers at each frame start. A downstream packer or DMA engine can therefore rely on every word of a frame having the same layout.

Top module: `cam_pixel_formatter`

## Requirements
- R1: After a synchronous reset, `pix_valid`, `pix_sof` and `pix_sol` are low and stay low until a complete pixel has been received.
- R2: With `cfg_pclk_rise`=1 the data and sync lines are sampled on the rising edge of the pixel clock. With 0 they are sampled on the falling edge. The values present at the other edge are never used.
- R3: `cfg_hsync_high` and `cfg_vsync_high` give the active level of each sync line (1 = active high, 0 = active low). Bytes are taken only while the horizontal sync is active. A frame starts when the vertical sync is active at a sampling edge after being inactive at the previous one.
- R4: With YCbCr input (`cfg_in_rgb`=0), the byte order code selects the arrival order: 0 = Y0,U,Y1,V; 1 = Y0,V,Y1,U; 2 = U,Y0,V,Y1; 3 = V,Y0,U,Y1. In format 0 the block emits the word {Y0,U} and then the word {Y1,V}. The luma is in bits 15:8 and the chroma in bits 7:0.
- R5: With RGB565 input (`cfg_in_rgb`=1), the byte order code selects the layout of the first and second byte: 0 = {R,G[5:3]},{G[2:0],B}; 1 = {B,G[5:3]},{G[2:0],R}; 2 = {G[2:0],B},{R,G[5:3]}; 3 = {G[2:0],R},{B,G[5:3]}. Output format 3 emits {R,G,B} in bits 15:11, 10:5 and 4:0.
- R6: Output format 1 (luma only) emits {8'h00,Y} for each pixel of YCbCr input.
- R7: Output format 2 (RGB555) emits {1'b0,R,G[5:1],B}, which drops the least significant green bit.
- R8: In YCbCr formats, each output Y, U and V value equals the received component ANDed with its 8-bit mask.
- R9: When `cfg_mono` is set, the chroma byte of every YCbCr output word is 8'h80, whatever chroma was received and whatever the chroma masks are.
- R10: The byte phase restarts at the start of every active line, so the leftover bytes of an incomplete pixel at the end of a line produce no output.
- R11: Input format, byte order, output format, monochrome and masks are taken only at a frame start. A change made in mid-frame has no effect until the next frame. The sampling edge and sync polarities take effect at once.
- R12: Combinations that would need colour-space conversion produce no output words: YCbCr input with format 2 or 3, and RGB input with format 0 or 1.
- R13: `pix_sof` is high with the first word of a frame, and `pix_sol` is high with the first word of every line. Both are low on all other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sen_pclk | input | 1 | Sensor pixel clock, oversampled |
| sen_hsync | input | 1 | Sensor horizontal sync / line-valid |
| sen_vsync | input | 1 | Sensor vertical sync |
| sen_data | input | 8 | Sensor data byte |
| cfg_pclk_rise | input | 1 | 1 = sample on rising pixel-clock edge, 0 = falling |
| cfg_hsync_high | input | 1 | Horizontal sync active level |
| cfg_vsync_high | input | 1 | Vertical sync active level |
| cfg_in_rgb | input | 1 | 0 = YCbCr 4:2:2 input, 1 = RGB565 input |
| cfg_byte_order | input | 2 | Byte order code |
| cfg_out_fmt | input | 2 | 0 YCbCr422, 1 luma only, 2 RGB555, 3 RGB565 |
| cfg_mono | input | 1 | Monochrome: neutral chroma |
| cfg_mask_y | input | 8 | Luma posterize mask |
| cfg_mask_u | input | 8 | U posterize mask |
| cfg_mask_v | input | 8 | V posterize mask |
| pix_valid | output | 1 | Output word strobe |
| pix_data | output | 16 | Output pixel word |
| pix_sof | output | 1 | First word of frame |
| pix_sol | output | 1 | First word of line |

## Verification
The bench builds the block with its default two-stage synchronizer and a neutral chroma of 8'h80. It drives the pixel clock at seven system cycles per byte. That spacing leaves enough room for the second word of a YCbCr pair to drain before the next group can complete. It also lets the bench move the data bus between the two pixel-clock edges, so a design sampling on the wrong edge would receive the inverted byte. Every byte order of both input formats and every output format are applied, in both sampling-edge modes and both sync polarities, together with incomplete lines and settings changed in mid-frame.

// File: rtl/cam_pix_pkg.sv
package cam_pix_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [1:0] OF_YCC   = 2'd0;
  localparam logic [1:0] OF_LUMA  = 2'd1;
  localparam logic [1:0] OF_RGB15 = 2'd2;
  localparam logic [1:0] OF_RGB16 = 2'd3;

  // Settings captured at frame start
  typedef struct packed {
    logic              in_rgb;
    logic [1:0]        order;
    logic [1:0]        out_fmt;
    logic              mono;
    logic [BYTE_W-1:0] mask_y;
    logic [BYTE_W-1:0] mask_u;
    logic [BYTE_W-1:0] mask_v;
  } fmt_cfg_t;

  localparam fmt_cfg_t CFG_RESET = '{1'b0, 2'd0, 2'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF};

  typedef struct packed {
    logic [BYTE_W-1:0] y0;
    logic [BYTE_W-1:0] cu;
    logic [BYTE_W-1:0] y1;
    logic [BYTE_W-1:0] cv;
  } yuv_pair_t;

  // Index i of b holds the i-th received byte of the group
  function automatic yuv_pair_t yuv_unpack(input logic [1:0] ord,
                                           input logic [3:0][BYTE_W-1:0] b);
    yuv_pair_t p;
    case (ord)
      2'd0:    p = '{b[0], b[1], b[2], b[3]};
      2'd1:    p = '{b[0], b[3], b[2], b[1]};
      2'd2:    p = '{b[1], b[0], b[3], b[2]};
      default: p = '{b[1], b[2], b[3], b[0]};
    endcase
    return p;
  endfunction

  // Returns {R[4:0], G[5:0], B[4:0]}
  function automatic logic [WORD_W-1:0] rgb_unpack(input logic [1:0] ord,
                                                   input logic [BYTE_W-1:0] b0,
                                                   input logic [BYTE_W-1:0] b1);
    logic [4:0] r, bl;
    logic [5:0] g;
    case (ord)
      2'd0: begin r = b0[7:3]; g = {b0[2:0], b1[7:5]}; bl = b1[4:0]; end
      2'd1: begin bl = b0[7:3]; g = {b0[2:0], b1[7:5]}; r = b1[4:0]; end
      2'd2: begin bl = b0[4:0]; g = {b1[2:0], b0[7:5]}; r = b1[7:3]; end
      default: begin r = b0[4:0]; g = {b1[2:0], b0[7:5]}; bl = b1[7:3]; end
    endcase
    return {r, g, bl};
  endfunction

endpackage

// File: rtl/cam_sync_sampler.sv
module cam_sync_sampler
  import cam_pix_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sen_pclk,
  input  logic              sen_hsync,
  input  logic              sen_vsync,
  input  logic [BYTE_W-1:0] sen_data,
  input  logic              rise_edge,
  input  logic              hs_high,
  input  logic              vs_high,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q,
  output logic              line_start,
  output logic              line_idle,
  output logic              frame_start
);

  localparam int BUS_W = 3 + BYTE_W;

  logic [BUS_W-1:0] chain [SYNC_STAGES];

  // All sensor lines travel through the same number of stages
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= {sen_pclk, sen_hsync, sen_vsync, sen_data};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  logic              s_pclk, s_hs, s_vs;
  logic [BYTE_W-1:0] s_data;
  assign {s_pclk, s_hs, s_vs, s_data} = chain[SYNC_STAGES-1];

  logic pclk_d, hs_seen, vs_seen;
  logic pix_edge, hs_on, vs_on;

  always_comb begin
    pix_edge = rise_edge ? (s_pclk & ~pclk_d) : (~s_pclk & pclk_d);
    hs_on    = (s_hs == hs_high);
    vs_on    = (s_vs == vs_high);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_d      <= 1'b0;
      hs_seen     <= 1'b0;
      vs_seen     <= 1'b0;
      byte_stb    <= 1'b0;
      byte_q      <= '0;
      line_start  <= 1'b0;
      line_idle   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      pclk_d      <= s_pclk;
      byte_stb    <= pix_edge & hs_on;
      line_start  <= pix_edge & hs_on & ~hs_seen;
      line_idle   <= pix_edge & ~hs_on;
      frame_start <= pix_edge & vs_on & ~vs_seen;
      if (pix_edge) begin
        hs_seen <= hs_on;
        vs_seen <= vs_on;
        byte_q  <= s_data;
      end
    end
  end

  // R2: a single pixel-clock edge yields at most one byte
  a_r2_one_byte_per_edge: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);

endmodule

// File: rtl/cam_cfg_shadow.sv
module cam_cfg_shadow
  import cam_pix_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_start,
  input  fmt_cfg_t cfg_live,
  output fmt_cfg_t cfg_frame
);

  always_ff @(posedge clk) begin
    if (rst)              cfg_frame <= CFG_RESET;
    else if (frame_start) cfg_frame <= cfg_live;
  end

endmodule

// File: rtl/cam_byte_gather.sv
module cam_byte_gather
  import cam_pix_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_rgb,
  input  logic                   byte_stb,
  input  logic [BYTE_W-1:0]      byte_q,
  input  logic                   line_start,
  input  logic                   line_idle,
  input  logic                   frame_start,
  output logic                   grp_valid,
  output logic [3:0][BYTE_W-1:0] grp_bytes,
  output logic                   grp_sof,
  output logic                   grp_sol
);

  logic [1:0]              phase;
  logic [3:0][BYTE_W-1:0]  held;
  logic                    sof_pend, sol_pend;
  logic [1:0]              idx;
  logic                    last;
  logic [3:0][BYTE_W-1:0]  merged;

  always_comb begin
    idx         = line_start ? 2'd0 : phase;
    last        = (idx == (in_rgb ? 2'd1 : 2'd3));
    merged      = held;
    merged[idx] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      held      <= '0;
      sof_pend  <= 1'b0;
      sol_pend  <= 1'b0;
      grp_valid <= 1'b0;
      grp_bytes <= '0;
      grp_sof   <= 1'b0;
      grp_sol   <= 1'b0;
    end else begin
      grp_valid <= 1'b0;
      if (frame_start) begin
        phase    <= '0;
        sof_pend <= 1'b1;
      end else if (line_idle) begin
        phase <= '0;
      end else if (byte_stb) begin
        held <= merged;
        if (last) begin
          grp_valid <= 1'b1;
          grp_bytes <= merged;
          grp_sof   <= sof_pend;
          grp_sol   <= sol_pend | line_start;
          sof_pend  <= 1'b0;
          sol_pend  <= 1'b0;
          phase     <= '0;
        end else begin
          phase <= idx + 2'd1;
          if (line_start) sol_pend <= 1'b1;
        end
      end
    end
  end

  // R10: a two-byte pixel never leaves the phase past its second byte
  a_r10_rgb_phase_bound: assert property (@(posedge clk) disable iff (rst)
    in_rgb |-> (phase < 2'd2));

endmodule

// File: rtl/cam_word_builder.sv
module cam_word_builder
  import cam_pix_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MONO_CHROMA = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst,
  input  fmt_cfg_t               cfg,
  input  logic                   grp_valid,
  input  logic [3:0][BYTE_W-1:0] grp_bytes,
  input  logic                   grp_sof,
  input  logic                   grp_sol,
  output logic                   pix_valid,
  output logic [WORD_W-1:0]      pix_data,
  output logic                   pix_sof,
  output logic                   pix_sol
);

  yuv_pair_t           yp;
  logic [BYTE_W-1:0]   y0m, y1m, cu_eff, cv_eff;
  logic [WORD_W-1:0]   w_first, w_second, rgb16, rgb_word;
  logic                legal, luma_only;
  logic                pend;
  logic [WORD_W-1:0]   pend_word;

  always_comb begin
    yp        = yuv_unpack(cfg.order, grp_bytes);
    y0m       = yp.y0 & cfg.mask_y;
    y1m       = yp.y1 & cfg.mask_y;
    cu_eff    = cfg.mono ? MONO_CHROMA : (yp.cu & cfg.mask_u);
    cv_eff    = cfg.mono ? MONO_CHROMA : (yp.cv & cfg.mask_v);
    luma_only = (cfg.out_fmt == OF_LUMA);
    w_first   = luma_only ? {{BYTE_W{1'b0}}, y0m} : {y0m, cu_eff};
    w_second  = luma_only ? {{BYTE_W{1'b0}}, y1m} : {y1m, cv_eff};
    rgb16     = rgb_unpack(cfg.order, grp_bytes[0], grp_bytes[1]);
    rgb_word  = (cfg.out_fmt == OF_RGB15) ?
                {1'b0, rgb16[15:11], rgb16[10:6], rgb16[4:0]} : rgb16;
    legal     = (cfg.in_rgb == cfg.out_fmt[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_sof   <= 1'b0;
      pix_sol   <= 1'b0;
      pend      <= 1'b0;
      pend_word <= '0;
    end else if (grp_valid && legal) begin
      pix_valid <= 1'b1;
      pix_data  <= cfg.in_rgb ? rgb_word : w_first;
      pix_sof   <= grp_sof;
      pix_sol   <= grp_sol;
      pend      <= ~cfg.in_rgb;
      pend_word <= w_second;
    end else if (pend) begin
      pix_valid <= 1'b1;
      pix_data  <= pend_word;
      pix_sof   <= 1'b0;
      pix_sol   <= 1'b0;
      pend      <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_sol   <= 1'b0;
    end
  end

  // R6: luma-only words carry nothing in the upper byte
  a_r6_luma_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg.out_fmt == OF_LUMA) |-> (pix_data[WORD_W-1:BYTE_W] == '0));

  // R7: RGB555 words keep the top bit clear
  a_r7_rgb15_top_clear: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg.out_fmt == OF_RGB15) |-> !pix_data[WORD_W-1]);

  // R13: frame marker only rides on a valid word
  a_r13_sof_with_valid: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> pix_valid);

endmodule

// File: rtl/cam_pixel_formatter.sv
module cam_pixel_formatter
  import cam_pix_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  MONO_CHROMA = 8'h80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sen_pclk,
  input  logic        sen_hsync,
  input  logic        sen_vsync,
  input  logic [7:0]  sen_data,
  input  logic        cfg_pclk_rise,
  input  logic        cfg_hsync_high,
  input  logic        cfg_vsync_high,
  input  logic        cfg_in_rgb,
  input  logic [1:0]  cfg_byte_order,
  input  logic [1:0]  cfg_out_fmt,
  input  logic        cfg_mono,
  input  logic [7:0]  cfg_mask_y,
  input  logic [7:0]  cfg_mask_u,
  input  logic [7:0]  cfg_mask_v,
  output logic        pix_valid,
  output logic [15:0] pix_data,
  output logic        pix_sof,
  output logic        pix_sol
);

  logic                   byte_stb, line_start, line_idle, frame_start;
  logic [BYTE_W-1:0]      byte_q;
  fmt_cfg_t               cfg_live, cfg_frame;
  logic                   grp_valid, grp_sof, grp_sol;
  logic [3:0][BYTE_W-1:0] grp_bytes;

  assign cfg_live = '{cfg_in_rgb, cfg_byte_order, cfg_out_fmt, cfg_mono,
                      cfg_mask_y, cfg_mask_u, cfg_mask_v};

  cam_sync_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk        (clk),
    .rst        (rst),
    .sen_pclk   (sen_pclk),
    .sen_hsync  (sen_hsync),
    .sen_vsync  (sen_vsync),
    .sen_data   (sen_data),
    .rise_edge  (cfg_pclk_rise),
    .hs_high    (cfg_hsync_high),
    .vs_high    (cfg_vsync_high),
    .byte_stb   (byte_stb),
    .byte_q     (byte_q),
    .line_start (line_start),
    .line_idle  (line_idle),
    .frame_start(frame_start)
  );

  cam_cfg_shadow u_shadow (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .cfg_live   (cfg_live),
    .cfg_frame  (cfg_frame)
  );

  cam_byte_gather u_gather (
    .clk        (clk),
    .rst        (rst),
    .in_rgb     (cfg_frame.in_rgb),
    .byte_stb   (byte_stb),
    .byte_q     (byte_q),
    .line_start (line_start),
    .line_idle  (line_idle),
    .frame_start(frame_start),
    .grp_valid  (grp_valid),
    .grp_bytes  (grp_bytes),
    .grp_sof    (grp_sof),
    .grp_sol    (grp_sol)
  );

  cam_word_builder #(.MONO_CHROMA(MONO_CHROMA)) u_builder (
    .clk       (clk),
    .rst       (rst),
    .cfg       (cfg_frame),
    .grp_valid (grp_valid),
    .grp_bytes (grp_bytes),
    .grp_sof   (grp_sof),
    .grp_sol   (grp_sol),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_sof   (pix_sof),
    .pix_sol   (pix_sol)
  );

  // R12: no word leaves under a format pair that needs colour conversion
  a_r12_legal_pair_only: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (cfg_frame.in_rgb == cfg_frame.out_fmt[1]));

endmodule

// File: tb/test_cam_pixel_formatter.sv
module test_cam_pixel_formatter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sen_pclk = 1'b0, sen_hsync = 1'b0, sen_vsync = 1'b0;
  logic [7:0]  sen_data = 8'h00;
  logic        cfg_pclk_rise = 1'b1, cfg_hsync_high = 1'b1, cfg_vsync_high = 1'b1;
  logic        cfg_in_rgb = 1'b0, cfg_mono = 1'b0;
  logic [1:0]  cfg_byte_order = 2'd0, cfg_out_fmt = 2'd0;
  logic [7:0]  cfg_mask_y = 8'hFF, cfg_mask_u = 8'hFF, cfg_mask_v = 8'hFF;
  logic        pix_valid, pix_sof, pix_sol;
  logic [15:0] pix_data;

  always #5 clk = ~clk;

  cam_pixel_formatter i_cam_pixel_formatter (
    .clk(clk), .rst(rst),
    .sen_pclk(sen_pclk), .sen_hsync(sen_hsync), .sen_vsync(sen_vsync), .sen_data(sen_data),
    .cfg_pclk_rise(cfg_pclk_rise), .cfg_hsync_high(cfg_hsync_high), .cfg_vsync_high(cfg_vsync_high),
    .cfg_in_rgb(cfg_in_rgb), .cfg_byte_order(cfg_byte_order), .cfg_out_fmt(cfg_out_fmt),
    .cfg_mono(cfg_mono), .cfg_mask_y(cfg_mask_y), .cfg_mask_u(cfg_mask_u), .cfg_mask_v(cfg_mask_v),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_sol(pix_sol)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [17:0] got_q[$];
  logic [17:0] exp_q[$];
  logic [7:0]  lb[$];
  // settings expected to be in force for the frame being checked
  logic [1:0]  e_fmt;
  logic        e_mono;
  logic [7:0]  e_my, e_mu, e_mv;

  always @(negedge clk) if (!rst && pix_valid) got_q.push_back({pix_sof, pix_sol, pix_data});

  task automatic set_cfg(input logic rgb, input logic [1:0] ord, input logic [1:0] fmt,
                         input logic mono, input logic [7:0] my, input logic [7:0] mu,
                         input logic [7:0] mv);
    cfg_in_rgb = rgb; cfg_byte_order = ord; cfg_out_fmt = fmt; cfg_mono = mono;
    cfg_mask_y = my; cfg_mask_u = mu; cfg_mask_v = mv;
    e_fmt = fmt; e_mono = mono; e_my = my; e_mu = mu; e_mv = mv;
  endtask

  // data is wrong at the non-sampling edge so a wrong-edge capture is visible
  task automatic drive_byte(input logic [7:0] b, input logic hs_on, input logic vs_on);
    @(negedge clk);
    sen_pclk  = ~cfg_pclk_rise;
    sen_hsync = hs_on ? cfg_hsync_high : ~cfg_hsync_high;
    sen_vsync = vs_on ? cfg_vsync_high : ~cfg_vsync_high;
    @(negedge clk); sen_data = b;
    repeat (2) @(negedge clk); sen_pclk = cfg_pclk_rise;
    repeat (2) @(negedge clk); sen_data = ~b;
    @(negedge clk);
  endtask

  task automatic frame_pulse();
    drive_byte(8'h00, 1'b0, 1'b1);
    drive_byte(8'h00, 1'b0, 1'b1);
    drive_byte(8'h00, 1'b0, 1'b0);
  endtask

  task automatic send_line();
    foreach (lb[i]) drive_byte(lb[i], 1'b1, 1'b0);
    drive_byte(8'h00, 1'b0, 1'b0);
    lb.delete();
  endtask

  task automatic push_yuv(input logic [1:0] ord, input logic [7:0] y0, input logic [7:0] u,
                          input logic [7:0] y1, input logic [7:0] v);
    case (ord)
      2'd0: begin lb.push_back(y0); lb.push_back(u); lb.push_back(y1); lb.push_back(v); end
      2'd1: begin lb.push_back(y0); lb.push_back(v); lb.push_back(y1); lb.push_back(u); end
      2'd2: begin lb.push_back(u); lb.push_back(y0); lb.push_back(v); lb.push_back(y1); end
      default: begin lb.push_back(v); lb.push_back(y0); lb.push_back(u); lb.push_back(y1); end
    endcase
  endtask

  task automatic push_rgb(input logic [1:0] ord, input logic [4:0] r, input logic [5:0] g,
                          input logic [4:0] b);
    case (ord)
      2'd0: begin lb.push_back({r, g[5:3]}); lb.push_back({g[2:0], b}); end
      2'd1: begin lb.push_back({b, g[5:3]}); lb.push_back({g[2:0], r}); end
      2'd2: begin lb.push_back({g[2:0], b}); lb.push_back({r, g[5:3]}); end
      default: begin lb.push_back({g[2:0], r}); lb.push_back({b, g[5:3]}); end
    endcase
  endtask

  function automatic logic [15:0] yword(input logic [7:0] y, input logic [7:0] c,
                                        input logic [7:0] cm);
    logic [7:0] ce;
    ce = e_mono ? 8'h80 : (c & cm);
    if (e_fmt == 2'd1) return {8'h00, y & e_my};
    return {y & e_my, ce};
  endfunction

  task automatic exp_yuv(input logic [7:0] y0, input logic [7:0] u, input logic [7:0] y1,
                         input logic [7:0] v, input logic sof, input logic sol);
    exp_q.push_back({sof, sol, yword(y0, u, e_mu)});
    exp_q.push_back({2'b00, yword(y1, v, e_mv)});
  endtask

  task automatic exp_rgb(input logic [4:0] r, input logic [5:0] g, input logic [4:0] b,
                         input logic sof, input logic sol);
    if (e_fmt == 2'd2) exp_q.push_back({sof, sol, 1'b0, r, g[5:1], b});
    else               exp_q.push_back({sof, sol, r, g, b});
  endtask

  task automatic check_stream(input string tag);
    repeat (10) @(negedge clk);
    n_chk++;
    if (got_q.size() != exp_q.size()) begin
      n_fail++;
      $display("FAIL %s word count actual=%0d expected=%0d", tag, got_q.size(), exp_q.size());
    end
    foreach (exp_q[i]) begin
      n_chk++;
      if (i >= got_q.size()) begin
        n_fail++;
        $display("FAIL %s word %0d actual=missing expected=%h", tag, i, exp_q[i]);
      end else if (got_q[i] !== exp_q[i]) begin
        n_fail++;
        $display("FAIL %s word %0d actual=%h expected=%h", tag, i, got_q[i], exp_q[i]);
      end
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    n_chk++;
    if (pix_valid !== 1'b0 || pix_sof !== 1'b0 || pix_sol !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs actual=%b%b%b expected=000", pix_valid, pix_sof, pix_sol);
    end
    check_stream("R1");
  endtask

  // R4 orders, two lines per frame so R13 markers are seen
  task automatic t_yuv_orders();
    for (int o = 0; o < 4; o++) begin
      set_cfg(1'b0, 2'(o), 2'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
      frame_pulse();
      push_yuv(2'(o), 8'h11 + 8'(o), 8'h52, 8'h93, 8'hD4);
      send_line();
      push_yuv(2'(o), 8'h21, 8'h62, 8'hA3, 8'hE4 - 8'(o));
      push_yuv(2'(o), 8'h35, 8'h76, 8'hB7, 8'hF8);
      send_line();
      exp_yuv(8'h11 + 8'(o), 8'h52, 8'h93, 8'hD4, 1'b1, 1'b1);
      exp_yuv(8'h21, 8'h62, 8'hA3, 8'hE4 - 8'(o), 1'b0, 1'b1);
      exp_yuv(8'h35, 8'h76, 8'hB7, 8'hF8, 1'b0, 1'b0);
      check_stream("R4/R13");
    end
  endtask

  task automatic t_rgb_orders();
    for (int o = 0; o < 4; o++) begin
      set_cfg(1'b1, 2'(o), 2'd3, 1'b0, 8'hFF, 8'hFF, 8'hFF);
      frame_pulse();
      push_rgb(2'(o), 5'h1B, 6'h2D, 5'h06);
      push_rgb(2'(o), 5'h04, 6'h13, 5'h19 + 5'(o));
      send_line();
      exp_rgb(5'h1B, 6'h2D, 5'h06, 1'b1, 1'b1);
      exp_rgb(5'h04, 6'h13, 5'h19 + 5'(o), 1'b0, 1'b0);
      check_stream("R5");
    end
  endtask

  task automatic t_falling_edge();
    cfg_pclk_rise = 1'b0;
    set_cfg(1'b1, 2'd0, 2'd3, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_rgb(2'd0, 5'h0E, 6'h35, 5'h11);
    send_line();
    exp_rgb(5'h0E, 6'h35, 5'h11, 1'b1, 1'b1);
    check_stream("R2");
    cfg_pclk_rise = 1'b1;
  endtask

  task automatic t_polarity();
    cfg_hsync_high = 1'b0;
    cfg_vsync_high = 1'b0;
    set_cfg(1'b0, 2'd0, 2'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_yuv(2'd0, 8'h44, 8'h55, 8'h66, 8'h77);
    send_line();
    exp_yuv(8'h44, 8'h55, 8'h66, 8'h77, 1'b1, 1'b1);
    check_stream("R3");
    cfg_hsync_high = 1'b1;
    cfg_vsync_high = 1'b1;
  endtask

  task automatic t_luma_only();
    set_cfg(1'b0, 2'd2, 2'd1, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_yuv(2'd2, 8'hC3, 8'h5A, 8'h3C, 8'hA5);
    send_line();
    exp_yuv(8'hC3, 8'h5A, 8'h3C, 8'hA5, 1'b1, 1'b1);
    check_stream("R6");
  endtask

  task automatic t_rgb555();
    set_cfg(1'b1, 2'd1, 2'd2, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_rgb(2'd1, 5'h1F, 6'h3F, 5'h01);
    push_rgb(2'd1, 5'h10, 6'h21, 5'h0A);
    send_line();
    exp_rgb(5'h1F, 6'h3F, 5'h01, 1'b1, 1'b1);
    exp_rgb(5'h10, 6'h21, 5'h0A, 1'b0, 1'b0);
    check_stream("R7");
  endtask

  task automatic t_posterize();
    set_cfg(1'b0, 2'd3, 2'd0, 1'b0, 8'hF0, 8'h3C, 8'h0F);
    frame_pulse();
    push_yuv(2'd3, 8'hB7, 8'hE6, 8'h5D, 8'h9B);
    send_line();
    exp_yuv(8'hB7, 8'hE6, 8'h5D, 8'h9B, 1'b1, 1'b1);
    check_stream("R8");
  endtask

  task automatic t_mono();
    set_cfg(1'b0, 2'd1, 2'd0, 1'b1, 8'hFF, 8'h00, 8'h0F);
    frame_pulse();
    push_yuv(2'd1, 8'h29, 8'h13, 8'hE1, 8'hC7);
    send_line();
    exp_yuv(8'h29, 8'h13, 8'hE1, 8'hC7, 1'b1, 1'b1);
    check_stream("R9");
  endtask

  task automatic t_partial_line();
    set_cfg(1'b0, 2'd0, 2'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_yuv(2'd0, 8'h01, 8'h02, 8'h03, 8'h04);
    lb.push_back(8'hEE);
    lb.push_back(8'hDD);
    send_line();
    push_yuv(2'd0, 8'h05, 8'h06, 8'h07, 8'h08);
    send_line();
    exp_yuv(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, 1'b1);
    exp_yuv(8'h05, 8'h06, 8'h07, 8'h08, 1'b0, 1'b1);
    check_stream("R10");
  endtask

  task automatic t_frame_latch();
    set_cfg(1'b0, 2'd0, 2'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    cfg_byte_order = 2'd1;
    cfg_mask_y     = 8'h0F;
    push_yuv(2'd0, 8'h9A, 8'h8B, 8'h7C, 8'h6D);
    send_line();
    exp_yuv(8'h9A, 8'h8B, 8'h7C, 8'h6D, 1'b1, 1'b1);
    check_stream("R11");
    e_my = 8'h0F;
    frame_pulse();
    push_yuv(2'd1, 8'h9A, 8'h8B, 8'h7C, 8'h6D);
    send_line();
    exp_yuv(8'h9A, 8'h8B, 8'h7C, 8'h6D, 1'b1, 1'b1);
    check_stream("R11");
  endtask

  task automatic t_illegal_pairs();
    set_cfg(1'b0, 2'd0, 2'd3, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_yuv(2'd0, 8'h12, 8'h34, 8'h56, 8'h78);
    send_line();
    check_stream("R12");
    set_cfg(1'b1, 2'd0, 2'd0, 1'b0, 8'hFF, 8'hFF, 8'hFF);
    frame_pulse();
    push_rgb(2'd0, 5'h03, 6'h07, 5'h0F);
    send_line();
    check_stream("R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    e_fmt = 2'd0; e_mono = 1'b0; e_my = 8'hFF; e_mu = 8'hFF; e_mv = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_yuv_orders();
    t_rgb_orders();
    t_falling_edge();
    t_polarity();
    t_luma_only();
    t_rgb555();
    t_posterize();
    t_mono();
    t_partial_line();
    t_frame_latch();
    t_illegal_pairs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule